// File: doc/BRIEF.md
# Timer and External Interrupt Control

This block holds an 8-bit control and flag register for two timers and two external interrupt inputs. For each timer it keeps a run bit, which it drives out as that timer's enable. It also latches an overflow flag whenever that timer reports a wrap. Each of the two active-low external inputs has a type bit that selects its sensing. With the type bit at 0 the input is sensed by level: the flag mirrors the pin while it is low. With the type bit at 1 the input is sensed on its falling edge: the flag latches on a high-to-low transition.

The flags clear in hardware when the interrupt controller acknowledges the vector for that source. An external flag in level mode ignores the acknowledge, because it simply follows the pin. Each flag is gated by its own enable input and by a global enable input to form a request output. The register port is a plain single-cycle write strobe with a combinational read. There is no data stream, so there is no back-pressure: a write is always taken in the cycle it is presented.

Top module: `tic_ctrl`

## Requirements
- R1: After reset the register reads 0x00. Its layout is: bit 7 timer 1 flag, bit 6 timer 1 run, bit 5 timer 0 flag, bit 4 timer 0 run, bit 3 external 1 flag, bit 2 external 1 type, bit 1 external 0 flag, bit 0 external 0 type.
- R2: A one-cycle pulse on `tmr_ovf[i]` sets the flag of timer i at the next clock edge. The flag stays set afterwards.
- R3: A pulse on `ack_tmr[i]` clears the flag of timer i at the next clock edge.
- R4: `tmr_run[1]` and `tmr_run[0]` equal register bits 6 and 4. These bits change only through a register write.
- R5: A register write loads all eight bits. In that cycle the write takes priority over every hardware set and clear.
- R6: When a hardware set and an acknowledge hit the same flag in the same cycle, the flag ends up set.
- R7: `irq_tmr[i]` is high exactly while the timer i flag, `en_tmr[i]` and `glb_en` are all high.
- R8: In edge mode (type bit = 1), a high-to-low transition on `ext_n[i]` sets the external flag i three clock edges later. A pin that stays low does not set the flag again.
- R9: In edge mode, `ack_ext[i]` clears the external flag i at the next clock edge.
- R10: In level mode (type bit = 0), the external flag i equals the inverted pin, delayed by three clock edges. `ack_ext[i]` has no effect in this mode.
- R11: `irq_ext[i]` is high exactly while the external flag i, `en_ext[i]` and `glb_en` are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Current register contents |
| tmr_ovf | input | 2 | One-cycle overflow pulses from timers 1:0 |
| tmr_run | output | 2 | Run enables to timers 1:0 |
| ext_n | input | 2 | Asynchronous active-low external interrupt pins |
| ack_tmr | input | 2 | Vector acknowledge for timers 1:0 |
| ack_ext | input | 2 | Vector acknowledge for external sources 1:0 |
| en_tmr | input | 2 | Per-timer request enables |
| en_ext | input | 2 | Per-external request enables |
| glb_en | input | 1 | Global request enable |
| irq_tmr | output | 2 | Timer interrupt requests |
| irq_ext | output | 2 | External interrupt requests |

## Verification
A flag's hardware set and its acknowledge clear can arrive in the same cycle. The bench provokes this for a timer by raising the overflow pulse and the acknowledge together. For an external input, it holds the acknowledge exactly over the third edge after a falling pin, which is the edge where the synchronized fall is detected. In both cases the flag must read as set afterwards. A register write colliding with an overflow pulse, and with a low level-mode pin, is also checked; there the written value must appear for one cycle.

// File: rtl/tic_pkg.sv
package tic_pkg;
  localparam int unsigned N_TMR  = 2;
  localparam int unsigned N_EXT  = 2;
  localparam int unsigned REG_W  = 2 * (N_TMR + N_EXT);
  localparam int unsigned TMR_LO = 2 * N_EXT;

  // field positions inside the control register
  function automatic int unsigned tmr_flag_bit(int unsigned i);
    return TMR_LO + 2 * i + 1;
  endfunction
  function automatic int unsigned tmr_run_bit(int unsigned i);
    return TMR_LO + 2 * i;
  endfunction
  function automatic int unsigned ext_flag_bit(int unsigned i);
    return 2 * i + 1;
  endfunction
  function automatic int unsigned ext_type_bit(int unsigned i);
    return 2 * i;
  endfunction

  typedef enum logic {SENSE_LEVEL = 1'b0, SENSE_FALL = 1'b1} sense_e;
endpackage

// File: rtl/tic_sync.sv
module tic_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2,
  parameter logic        IDLE   = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= {WIDTH{IDLE}};
      end else if (s == 0) begin
        stage_q[s] <= d_async;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
      end
    end
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/tic_tmr_chan.sv
module tic_tmr_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wr_flag,
  input  logic wr_run,
  input  logic ovf,
  input  logic ack,
  output logic flag,
  output logic run
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      run  <= 1'b0;
    end else if (wr) begin
      flag <= wr_flag;
      run  <= wr_run;
    end else begin
      if (ovf) begin
        flag <= 1'b1;
      end else if (ack) begin
        flag <= 1'b0;
      end
    end
  end

  // R2: an overflow outside a write leaves the flag set
  p_ovf_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !wr) |=> flag);
  // R3: an acknowledge alone clears the flag
  p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !ovf && !wr) |=> !flag);
  // R4: run bit is touched only by writes
  p_run_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(run));
endmodule

// File: rtl/tic_ext_chan.sv
module tic_ext_chan
  import tic_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic wr,
  input  logic wr_flag,
  input  logic wr_type,
  input  logic ack,
  output logic flag,
  output logic sense
);
  logic   prev_q;
  logic   fall;
  sense_e mode;

  assign mode = sense_e'(sense);
  assign fall = prev_q & ~pin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
    end else begin
      prev_q <= pin_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      sense <= 1'b0;
    end else if (wr) begin
      flag  <= wr_flag;
      sense <= wr_type;
    end else if (mode == SENSE_LEVEL) begin
      flag <= ~pin_s;
    end else if (fall) begin
      flag <= 1'b1;
    end else if (ack) begin
      flag <= 1'b0;
    end
  end

  // R8: a detected fall in edge mode sets the flag
  p_fall_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sense && fall && !wr) |=> flag);
  // R9: acknowledge clears an edge-mode flag
  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sense && ack && !fall && !wr) |=> !flag);
  // R10: acknowledge ignored while the level input is low
  p_level_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sense && ack && !pin_s && !wr) |=> flag);
endmodule

// File: rtl/tic_ctrl.sv
module tic_ctrl
  import tic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [N_TMR-1:0] tmr_ovf,
  output logic [N_TMR-1:0] tmr_run,
  input  logic [N_EXT-1:0] ext_n,
  input  logic [N_TMR-1:0] ack_tmr,
  input  logic [N_EXT-1:0] ack_ext,
  input  logic [N_TMR-1:0] en_tmr,
  input  logic [N_EXT-1:0] en_ext,
  input  logic             glb_en,
  output logic [N_TMR-1:0] irq_tmr,
  output logic [N_EXT-1:0] irq_ext
);
  localparam int unsigned SYNC_DEPTH = 2;

  logic [N_EXT-1:0] ext_s;
  logic [N_TMR-1:0] t_flag;
  logic [N_EXT-1:0] e_flag;
  logic [N_EXT-1:0] e_type;

  tic_sync #(.WIDTH(N_EXT), .STAGES(SYNC_DEPTH), .IDLE(1'b1)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (ext_n),
    .q_sync  (ext_s)
  );

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    tic_tmr_chan u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (reg_wr),
      .wr_flag (reg_wdata[tmr_flag_bit(i)]),
      .wr_run  (reg_wdata[tmr_run_bit(i)]),
      .ovf     (tmr_ovf[i]),
      .ack     (ack_tmr[i]),
      .flag    (t_flag[i]),
      .run     (tmr_run[i])
    );
    assign reg_rdata[tmr_flag_bit(i)] = t_flag[i];
    assign reg_rdata[tmr_run_bit(i)]  = tmr_run[i];
    assign irq_tmr[i] = t_flag[i] & en_tmr[i] & glb_en;
  end

  for (genvar i = 0; i < N_EXT; i++) begin : g_ext
    tic_ext_chan u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_s   (ext_s[i]),
      .wr      (reg_wr),
      .wr_flag (reg_wdata[ext_flag_bit(i)]),
      .wr_type (reg_wdata[ext_type_bit(i)]),
      .ack     (ack_ext[i]),
      .flag    (e_flag[i]),
      .sense   (e_type[i])
    );
    assign reg_rdata[ext_flag_bit(i)] = e_flag[i];
    assign reg_rdata[ext_type_bit(i)] = e_type[i];
    assign irq_ext[i] = e_flag[i] & en_ext[i] & glb_en;
  end

  // R5: a write lands in the register on the next edge
  p_write_loads_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (reg_rdata == $past(reg_wdata)));
  // R7: a timer request never rises without the global enable
  p_tmr_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_tmr != '0) |-> glb_en);
  // R11: an external request never rises without the global enable
  p_ext_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ext != '0) |-> glb_en);
  // R4: run outputs match the register view
  p_run_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tmr_run) == $countones({reg_rdata[6], reg_rdata[4]}));
endmodule

// File: tb/tic_ctrl_tb_top.sv
module tic_ctrl_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 10;
  // {wr, wdata[8], ovf[2], ack[2], en[2], glb, exp_rdata[8], exp_irq[2]}
  localparam logic [25:0] VEC [NVEC] = '{
    {1'b1, 8'h50, 2'b00, 2'b00, 2'b00, 1'b0, 8'h50, 2'b00},
    {1'b0, 8'h00, 2'b01, 2'b00, 2'b00, 1'b1, 8'h70, 2'b00},
    {1'b0, 8'h00, 2'b00, 2'b00, 2'b01, 1'b1, 8'h70, 2'b01},
    {1'b0, 8'h00, 2'b00, 2'b00, 2'b01, 1'b0, 8'h70, 2'b00},
    {1'b0, 8'h00, 2'b00, 2'b01, 2'b01, 1'b1, 8'h50, 2'b00},
    {1'b0, 8'h00, 2'b10, 2'b00, 2'b10, 1'b1, 8'hD0, 2'b10},
    {1'b0, 8'h00, 2'b10, 2'b10, 2'b10, 1'b1, 8'hD0, 2'b10},
    {1'b1, 8'h00, 2'b11, 2'b00, 2'b11, 1'b1, 8'h00, 2'b00},
    {1'b0, 8'h00, 2'b11, 2'b00, 2'b11, 1'b1, 8'hA0, 2'b11},
    {1'b0, 8'h00, 2'b00, 2'b11, 2'b11, 1'b1, 8'h00, 2'b00}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [1:0] tmr_ovf = '0, tmr_run, ext_n = 2'b11;
  logic [1:0] ack_tmr = '0, ack_ext = '0, en_tmr = '0, en_ext = '0;
  logic       glb_en = 1'b0;
  logic [1:0] irq_tmr, irq_ext;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tic_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tmr_ovf(tmr_ovf), .tmr_run(tmr_run),
    .ext_n(ext_n), .ack_tmr(ack_tmr), .ack_ext(ack_ext),
    .en_tmr(en_tmr), .en_ext(en_ext), .glb_en(glb_en),
    .irq_tmr(irq_tmr), .irq_ext(irq_ext)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(logic [7:0] v);
    reg_wr = 1'b1; reg_wdata = v;
    step();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    step(2);
    // R1 reset state
    chk("R1 reset rdata", reg_rdata, 8'h00);
    chk("R1 reset irq", {4'h0, irq_tmr, irq_ext}, 8'h00);
    chk("R4 reset run", {6'h0, tmr_run}, 8'h00);
    rst_n = 1'b1;
    step();

    // timer table: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NVEC; v++) begin
      {reg_wr, reg_wdata, tmr_ovf, ack_tmr, en_tmr, glb_en} = VEC[v][25:10];
      step();
      chk($sformatf("R2/R3/R5/R6 vec%0d rdata", v), reg_rdata, VEC[v][9:2]);
      chk($sformatf("R7 vec%0d irq_tmr", v), {6'h0, irq_tmr}, {6'h0, VEC[v][1:0]});
      if (v == 0) chk("R4 run out", {6'h0, tmr_run}, 8'h03);
    end
    reg_wr = 0; tmr_ovf = 0; ack_tmr = 0; en_tmr = 0;

    // edge mode on both external inputs
    en_ext = 2'b11; glb_en = 1'b1;
    wr_reg(8'h05);
    chk("R5 type write", reg_rdata, 8'h05);
    ext_n[0] = 1'b0;
    step(2);
    chk("R8 not yet after two edges", reg_rdata, 8'h05);
    step();
    chk("R8 fall sets flag", reg_rdata, 8'h07);
    chk("R11 irq_ext on", {6'h0, irq_ext}, 8'h01);
    step(3);
    chk("R8 steady low no change", reg_rdata, 8'h07);
    ack_ext[0] = 1'b1; step(); ack_ext[0] = 1'b0;
    chk("R9 ack clears", reg_rdata, 8'h05);
    step(2);
    chk("R8 held low no retrigger", reg_rdata, 8'h05);
    ext_n[0] = 1'b1; step(3);
    ext_n[0] = 1'b0; step(2);
    ack_ext[0] = 1'b1; step(); ack_ext[0] = 1'b0;
    chk("R6 fall beats ack", reg_rdata, 8'h07);
    glb_en = 1'b0; step();
    chk("R11 global off", {6'h0, irq_ext}, 8'h00);
    glb_en = 1'b1; en_ext = 2'b10; step();
    chk("R11 local enable off", {6'h0, irq_ext}, 8'h00);
    en_ext = 2'b11;
    ack_ext[0] = 1'b1; step(); ack_ext[0] = 1'b0;
    chk("R9 ack clears again", reg_rdata, 8'h05);

    // level mode
    ext_n[0] = 1'b1;
    wr_reg(8'h00);
    chk("R10 level idle", reg_rdata, 8'h00);
    ext_n[1] = 1'b0;
    step(2);
    chk("R10 level not yet", reg_rdata, 8'h00);
    step();
    chk("R10 level follows low", reg_rdata, 8'h08);
    chk("R11 irq_ext level", {6'h0, irq_ext}, 8'h02);
    ack_ext[1] = 1'b1; step(); ack_ext[1] = 1'b0;
    chk("R10 ack ignored", reg_rdata, 8'h08);
    wr_reg(8'h00);
    chk("R5 write beats level", reg_rdata, 8'h00);
    step();
    chk("R10 level reasserts", reg_rdata, 8'h08);
    ext_n[1] = 1'b1;
    step(2);
    chk("R10 release delayed", reg_rdata, 8'h08);
    step();
    chk("R10 release follows", reg_rdata, 8'h00);
    chk("R11 irq_ext released", {6'h0, irq_ext}, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule